// File: doc/BRIEF.md
# Clock Source Switch Controller

This block holds the control state for choosing the system clock source and runs the sequence that moves the system clock from one source to another. Software writes a requested source code, can lock the configuration, and raises a switch request. The sequencer compares the request with the source now in use. It then skips the request, or waits for the target's ready input and completes the switch.

An external fail-safe monitor can report a clock failure. The block then falls back at once to the internal fast RC source and raises a sticky fail flag. Software can also set the fail flag itself, which arms a switch request. The flag clears when a valid switch sequence begins. The clock multiplexer, the oscillators and the failure detector are outside this block; it drives only the registered source-select code.

Top module: `clk_src_switch_ctrl`

## Requirements
- R1: After a synchronous reset, the current source is 0, the requested source is 0, and the go, fail and lock bits are all 0.
- R2: A write takes effect only in a cycle where both `wr_en` and `unlock_ok` are high. A write without `unlock_ok` changes no field.
- R3: Write word layout: bits [3:0] are the requested source, bit 4 is go, bit 5 is the fail flag and bit 6 is lock. Writing 0 to go has no effect. Writing 1 sets go, which starts a switch to the requested source.
- R4: A switch to a valid, different source waits until that source's bit in `src_ready` is sampled high. Until then `cur_sel` keeps the old code and go stays 1. Ready bits of other sources do not complete the switch. On completion, `cur_sel` takes the target code and go clears.
- R5: If the requested code equals the current code, go clears on the clock edge after it was set, and `cur_sel` does not change.
- R6: Source codes are 0 fast RC, 1 PLL, 2 primary, 3 secondary and 4 low-power RC. Codes 5 to 15 are reserved. A request for a reserved code clears go one edge after it was set, and `cur_sel` never holds a reserved code.
- R7: Writing 1 to lock sets it. Writing 0 does not clear it; only reset does. While lock is set, writes to the requested-source field and to go are ignored.
- R8: A high `clk_fail` at a clock edge forces `cur_sel` to 0, clears go, sets the fail flag, and abandons any pending switch.
- R9: Writing 1 to the fail flag sets it and, when unlocked, also sets go. Writing 0 to it has no effect. The flag clears when a valid, non-redundant switch starts; a redundant or reserved request leaves it set.
- R10: Read word layout: bits [6:0] mirror the write layout (requested source, go, fail, lock), and bits [10:7] hold the current source code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| unlock_ok | input | 1 | Qualifier: the unlock sequence has been completed |
| wr_data | input | 7 | Write word |
| src_ready | input | 5 | Per-source clock ready |
| clk_fail | input | 1 | Clock failure event from the fail-safe monitor |
| rd_data | output | 11 | Read word |
| cur_sel | output | 4 | Current source select code |

## Verification
The hardest situation to reach is a failure event that lands while a switch is pending and the target's ready bit rises in the same cycle. The bench raises `clk_fail` and the target ready together during the wait state, and expects the fallback to win. The bench also sweeps every requested code, valid and reserved, from every valid current source. While each switch waits, it holds the ready bits of all other sources high, so that a completion on the wrong ready bit would show at `cur_sel`.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  localparam int DEF_SEL_W   = 4;
  localparam int DEF_NUM_SRC = 5;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_WAIT = 1'b1
  } seq_state_t;
endpackage

// File: rtl/clksw_cfg.sv
module clksw_cfg #(
  parameter int SEL_W = 4,
  localparam int WR_W = SEL_W + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             unlock_ok,
  input  logic [WR_W-1:0]  wr_data,
  output logic [SEL_W-1:0] req_src,
  output logic             locked,
  output logic             arm_go,
  output logic             arm_fail
);
  localparam int B_GO   = SEL_W;
  localparam int B_FAIL = SEL_W + 1;
  localparam int B_LOCK = SEL_W + 2;

  logic wr_ok;
  assign wr_ok = wr_en & unlock_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_src <= '0;
      locked  <= 1'b0;
    end else if (wr_ok) begin
      if (!locked) req_src <= wr_data[SEL_W-1:0];
      locked <= locked | wr_data[B_LOCK];
    end
  end

  assign arm_go   = wr_ok & ~locked & (wr_data[B_GO] | wr_data[B_FAIL]);
  assign arm_fail = wr_ok & wr_data[B_FAIL];
endmodule

// File: rtl/clksw_seq.sv
module clksw_seq
  import clksw_pkg::*;
#(
  parameter int SEL_W   = 4,
  parameter int NUM_SRC = 5,
  localparam int N_CODE = 1 << SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SEL_W-1:0]   req_src,
  input  logic               arm_go,
  input  logic               arm_fail,
  input  logic [NUM_SRC-1:0] src_ready,
  input  logic               clk_fail,
  output logic [SEL_W-1:0]   cur_src,
  output logic               go,
  output logic               fail_flag
);
  seq_state_t       state;
  logic [SEL_W-1:0] target;
  logic [N_CODE-1:0] ready_vec;
  logic             tgt_valid;
  logic             redundant;

  for (genvar g = 0; g < N_CODE; g++) begin : g_rdy
    if (g < NUM_SRC) begin : g_real
      assign ready_vec[g] = src_ready[g];
    end else begin : g_resv
      assign ready_vec[g] = 1'b0;
    end
  end

  assign tgt_valid = (int'(req_src) < NUM_SRC);
  assign redundant = (req_src == cur_src);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      target    <= '0;
      cur_src   <= '0;
      go        <= 1'b0;
      fail_flag <= 1'b0;
    end else if (clk_fail) begin
      state     <= SEQ_IDLE;
      cur_src   <= '0;
      go        <= 1'b0;
      fail_flag <= 1'b1;
    end else begin
      if (arm_go)   go        <= 1'b1;
      if (arm_fail) fail_flag <= 1'b1;
      case (state)
        SEQ_IDLE: begin
          if (go) begin
            if (!tgt_valid || redundant) begin
              go <= 1'b0;
            end else begin
              state     <= SEQ_WAIT;
              target    <= req_src;
              fail_flag <= 1'b0;
            end
          end
        end
        SEQ_WAIT: begin
          if (ready_vec[target]) begin
            cur_src <= target;
            go      <= 1'b0;
            state   <= SEQ_IDLE;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clk_src_switch_ctrl.sv
module clk_src_switch_ctrl
  import clksw_pkg::*;
#(
  parameter int SEL_W   = DEF_SEL_W,
  parameter int NUM_SRC = DEF_NUM_SRC,
  localparam int WR_W   = SEL_W + 3,
  localparam int RD_W   = 2 * SEL_W + 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               unlock_ok,
  input  logic [WR_W-1:0]    wr_data,
  input  logic [NUM_SRC-1:0] src_ready,
  input  logic               clk_fail,
  output logic [RD_W-1:0]    rd_data,
  output logic [SEL_W-1:0]   cur_sel
);
  logic [SEL_W-1:0] req_src;
  logic             locked;
  logic             arm_go;
  logic             arm_fail;
  logic             go;
  logic             fail_flag;
  logic [SEL_W-1:0] cur_src;

  clksw_cfg #(.SEL_W(SEL_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .unlock_ok(unlock_ok),
    .wr_data  (wr_data),
    .req_src  (req_src),
    .locked   (locked),
    .arm_go   (arm_go),
    .arm_fail (arm_fail)
  );

  clksw_seq #(.SEL_W(SEL_W), .NUM_SRC(NUM_SRC)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req_src  (req_src),
    .arm_go   (arm_go),
    .arm_fail (arm_fail),
    .src_ready(src_ready),
    .clk_fail (clk_fail),
    .cur_src  (cur_src),
    .go       (go),
    .fail_flag(fail_flag)
  );

  assign cur_sel = cur_src;
  assign rd_data = {cur_src, locked, fail_flag, go, req_src};
endmodule

// File: rtl/clksw_checker.sv
module clksw_checker #(
  parameter int SEL_W   = 4,
  parameter int NUM_SRC = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic               unlock_ok,
  input logic               clk_fail,
  input logic [NUM_SRC-1:0] src_ready,
  input logic [SEL_W-1:0]   cur_sel,
  input logic [SEL_W-1:0]   rd_req,
  input logic               rd_go,
  input logic               rd_fail,
  input logic               rd_lock,
  input logic [SEL_W-1:0]   rd_cur
);
  logic [NUM_SRC-1:0] rdy_q;
  always_ff @(posedge clk) rdy_q <= src_ready;

  // R1
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cur_sel == '0 && rd_req == '0 && !rd_go && !rd_fail && !rd_lock));

  // R2
  a_r2_no_write_no_change: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en && unlock_ok) |-> $stable(rd_req));

  // R4
  a_r4_switch_needs_ready: assert property (@(posedge clk) disable iff (rst)
    ((cur_sel != $past(cur_sel)) && !$past(clk_fail)) |->
      (|(rdy_q & (NUM_SRC'(1) << cur_sel))));

  // R6
  a_r6_never_reserved: assert property (@(posedge clk) disable iff (rst)
    int'(cur_sel) < NUM_SRC);

  // R7
  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(rd_lock) |-> rd_lock);

  // R8
  a_r8_fail_fallback: assert property (@(posedge clk) disable iff (rst)
    clk_fail |=> (cur_sel == '0 && !rd_go && rd_fail));

  // R10
  a_r10_read_cur: assert property (@(posedge clk) disable iff (rst)
    rd_cur == cur_sel);
endmodule

bind clk_src_switch_ctrl clksw_checker #(.SEL_W(SEL_W), .NUM_SRC(NUM_SRC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .unlock_ok(unlock_ok),
  .clk_fail (clk_fail),
  .src_ready(src_ready),
  .cur_sel  (cur_sel),
  .rd_req   (rd_data[SEL_W-1:0]),
  .rd_go    (rd_data[SEL_W]),
  .rd_fail  (rd_data[SEL_W+1]),
  .rd_lock  (rd_data[SEL_W+2]),
  .rd_cur   (rd_data[2*SEL_W+2:SEL_W+3])
);

// File: tb/sim_clk_src_switch_ctrl.sv
module sim_clk_src_switch_ctrl;
  localparam int SW = 4;
  localparam int NS = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          unlock_ok = 1'b0;
  logic [6:0]    wr_data = '0;
  logic [NS-1:0] src_ready = '0;
  logic          clk_fail = 1'b0;
  logic [10:0]   rd_data;
  logic [SW-1:0] cur_sel;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  clk_src_switch_ctrl #(.SEL_W(SW), .NUM_SRC(NS)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .unlock_ok(unlock_ok),
    .wr_data(wr_data), .src_ready(src_ready), .clk_fail(clk_fail),
    .rd_data(rd_data), .cur_sel(cur_sel)
  );

  localparam logic [6:0] GO   = 7'h10;
  localparam logic [6:0] FAIL = 7'h20;
  localparam logic [6:0] LOCK = 7'h40;

  function automatic int f_req();  return int'(rd_data[3:0]); endfunction
  function automatic int f_go();   return int'(rd_data[4]);   endfunction
  function automatic int f_fail(); return int'(rd_data[5]);   endfunction
  function automatic int f_lock(); return int'(rd_data[6]);   endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] d, input logic unl);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; unlock_ok = unl;
    @(negedge clk);
    wr_en = 1'b0; unlock_ok = 1'b0;
  endtask

  task automatic goto_src(input int a);
    wr(7'(a) | GO, 1'b1);
    @(negedge clk);
    src_ready = NS'(1) << a;
    @(negedge clk);
    src_ready = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 cur", int'(cur_sel), 0);
    check("R1 req", f_req(), 0);
    check("R1 go", f_go(), 0);
    check("R1 fail", f_fail(), 0);
    check("R1 lock", f_lock(), 0);

    // Sweep: every valid current source against every requested code
    for (int a = 0; a < NS; a++) begin
      for (int b = 0; b < 16; b++) begin
        goto_src(a);
        check("R4 setup", int'(cur_sel), a);
        wr(7'(b) | GO, 1'b1);
        check("R3 go set", f_go(), 1);
        @(negedge clk);
        if (b >= NS || b == a) begin
          check(b >= NS ? "R6 go cleared" : "R5 go cleared", f_go(), 0);
          idle(3);
          check(b >= NS ? "R6 cur kept" : "R5 cur kept", int'(cur_sel), a);
        end else begin
          src_ready = ~(NS'(1) << b);
          idle(3);
          check("R4 cur held", int'(cur_sel), a);
          check("R4 go pending", f_go(), 1);
          src_ready = NS'(1) << b;
          @(negedge clk);
          src_ready = '0;
          check("R4 cur new", int'(cur_sel), b);
          check("R4 go done", f_go(), 0);
        end
      end
    end

    // R8: failure during a pending switch, same cycle as target ready
    goto_src(0);
    wr(7'd2 | GO, 1'b1);
    @(negedge clk);
    clk_fail = 1'b1; src_ready = NS'(1) << 2;
    @(negedge clk);
    clk_fail = 1'b0; src_ready = '0;
    check("R8 cur", int'(cur_sel), 0);
    check("R8 go", f_go(), 0);
    check("R8 fail", f_fail(), 1);
    idle(2);
    check("R8 stays", int'(cur_sel), 0);

    // R8 while idle on another source
    goto_src(3);
    check("R8 pre", int'(cur_sel), 3);
    @(negedge clk); clk_fail = 1'b1;
    @(negedge clk); clk_fail = 1'b0;
    check("R8 idle fallback", int'(cur_sel), 0);

    // R9: software fail write starts a switch; flag clears on valid start
    wr(7'd2 | FAIL, 1'b1);
    check("R9 flag set", f_fail(), 1);
    check("R9 go armed", f_go(), 1);
    @(negedge clk);
    check("R9 flag cleared", f_fail(), 0);
    src_ready = NS'(1) << 2;
    @(negedge clk);
    src_ready = '0;
    check("R9 switched", int'(cur_sel), 2);
    // redundant fail write keeps the flag
    wr(7'd2 | FAIL, 1'b1);
    @(negedge clk);
    check("R9 redundant go", f_go(), 0);
    check("R9 redundant flag", f_fail(), 1);
    // writing 0 to the flag has no effect
    wr(7'd2, 1'b1);
    check("R9 zero write", f_fail(), 1);

    // R2: write without unlock is ignored
    wr(7'd3 | GO | LOCK, 1'b0);
    check("R2 req", f_req(), 2);
    check("R2 go", f_go(), 0);
    check("R2 lock", f_lock(), 0);
    idle(3);
    check("R2 cur", int'(cur_sel), 2);

    // R3: go written as 0 has no effect
    wr(7'd4, 1'b1);
    check("R3 req updated", f_req(), 4);
    check("R3 go zero", f_go(), 0);
    idle(3);
    check("R3 cur kept", int'(cur_sel), 2);

    // R7: lock
    wr(7'd4 | LOCK, 1'b1);
    check("R7 lock set", f_lock(), 1);
    wr(7'd1 | GO, 1'b1);
    check("R7 req frozen", f_req(), 4);
    check("R7 go ignored", f_go(), 0);
    wr(7'd0, 1'b1);
    check("R7 lock sticky", f_lock(), 1);
    src_ready = '1;
    idle(3);
    src_ready = '0;
    check("R7 cur kept", int'(cur_sel), 2);
    // R8 still acts while locked
    @(negedge clk); clk_fail = 1'b1;
    @(negedge clk); clk_fail = 1'b0;
    check("R8 locked fallback", int'(cur_sel), 0);
    // R7 only reset clears lock
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    @(negedge clk);
    check("R7 reset unlock", f_lock(), 0);
    check("R1 reset fail", f_fail(), 0);
    check("R10 read cur", int'(rd_data[10:7]), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule